// File: doc/BRIEF.md
# DMA Bus Arbiter with Session Watchdog

This block decides who owns a single shared system bus: the processor (integer and floating-point units together) or one external DMA master. The processor is the default owner and always yields to a pending DMA request, except while it runs a locked (indivisible) access, or while a transfer of its own is still on the bus. DMA ownership also depends on a software-controlled enable bit. The arbiter drives an active-low grant to the DMA master and a one-cycle memory-exception pulse toward the processor.

While the DMA master owns the bus, a session watchdog counts the cycles during which its request stays active. If the request is held for too long, or the bus reports a timeout during the session, the grant is taken back at once and the exception is raised. A master whose grant was taken back must first drop its request for at least one cycle before it can win the bus again. This gives the processor room to service the exception.

A write strobe loads two control bits: DMA enable, which resets to off, and watchdog enable, which resets to on. All inputs are sampled on the rising clock edge, and both outputs are registered.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), dma_gnt_n is 1 and mem_exc is 0. DMA is disabled, so a DMA request gets no grant until it is enabled. The watchdog is enabled.
- R2: With DMA enabled, dma_req_n low, cpu_lock low and bus_idle high at a clock edge, dma_gnt_n is 0 after that edge.
- R3: No grant is issued at an edge where cpu_lock is high.
- R4: No grant is issued at an edge where bus_idle is low, so that a processor transfer in flight is never cut off.
- R5: While DMA is disabled, no grant is issued. If DMA is disabled during a session, the grant is withdrawn at the first edge with bus_idle high, and no exception is raised.
- R6: During a session, the grant is withdrawn at an edge where dma_req_n is high and data_rdy_n is low, with no exception. While dma_req_n is high and data_rdy_n is high, the grant holds.
- R7: With the watchdog enabled and dma_req_n held low, dma_gnt_n stays 0 for exactly LIMIT (default 1024) cycles. In the next cycle, dma_gnt_n is 1 and mem_exc is 1.
- R8: With the watchdog disabled, a request held for longer than LIMIT cycles keeps the grant and raises no exception.
- R9: bus_tmo high at an edge during a session gives dma_gnt_n 1 and mem_exc 1 after that edge. bus_tmo has no effect while the processor owns the bus.
- R10: After a forced revocation (R7 or R9), no grant is issued while dma_req_n stays low. The grant can be issued again only after dma_req_n has been high at one edge.
- R11: mem_exc is never high in two consecutive cycles.
- R12: At an edge where cfg_we is high, cfg_dma_en and cfg_tmo_en are loaded as the DMA-enable and watchdog-enable bits, and they take effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Loads the two control bits |
| cfg_dma_en | input | 1 | DMA enable value to load |
| cfg_tmo_en | input | 1 | Watchdog enable value to load |
| dma_req_n | input | 1 | DMA bus request, active low |
| cpu_lock | input | 1 | Processor is running a locked access |
| bus_idle | input | 1 | No transfer in flight, so ownership may change |
| data_rdy_n | input | 1 | Data-ready handshake, active low |
| bus_tmo | input | 1 | Bus timeout indication |
| dma_gnt_n | output | 1 | DMA bus grant, active low |
| mem_exc | output | 1 | Memory exception, one-cycle pulse |

## Verification
A vector walk changes one blocking condition at a time: lock, busy bus, request high without a handshake, bus timeout during a session and while the processor owns the bus, and a request kept low after a revocation. Each of these shows which input alone holds the grant back or removes it. Directed runs hold the request long enough to reach the watchdog limit, once with the watchdog on and once with it off. They count the grant cycles exactly, which separates an off-by-one limit from a correct one. Further directed runs disable DMA before and during a session, to separate blocking a new grant from withdrawing an existing one at a bus idle point.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ST_CPU  = 2'd0,
        ST_DMA  = 2'd1,
        ST_HOLD = 2'd2
    } own_e;

    typedef struct packed {
        own_e owner;
        logic exc;
    } arb_state_t;

endpackage

// File: rtl/arb_cfg_reg.sv
module arb_cfg_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic dma_en_in,
    input  logic tmo_en_in,
    output logic dma_en,
    output logic tmo_en
);
    typedef struct packed {
        logic dma_en;
        logic tmo_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.dma_en = dma_en_in;
            cfg_d.tmo_en = tmo_en_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.dma_en <= 1'b0;
            cfg_q.tmo_en <= 1'b1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign dma_en = cfg_q.dma_en;
    assign tmo_en = cfg_q.tmo_en;

endmodule

// File: rtl/arb_sess_timer.sv
module arb_sess_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic granted,
    input  logic req_act,
    input  logic tmo_en,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT) + 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!granted) begin
            cnt_d = '0;
        end else if (req_act && (cnt_q != '1)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = granted && req_act && tmo_en && (cnt_q == LAST);

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (granted && tmo_en && $past(tmo_en)) |-> (cnt_q <= LAST));

    // R7
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!granted) |-> (cnt_q == '0));

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_dma_en,
    input  logic cfg_tmo_en,
    input  logic dma_req_n,
    input  logic cpu_lock,
    input  logic bus_idle,
    input  logic data_rdy_n,
    input  logic bus_tmo,
    output logic dma_gnt_n,
    output logic mem_exc
);
    import arb_pkg::*;

    logic dma_en, tmo_en, expire, req_act, granted;
    arb_state_t st_d, st_q;

    assign req_act = !dma_req_n;
    assign granted = (st_q.owner == ST_DMA);

    arb_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .dma_en_in (cfg_dma_en),
        .tmo_en_in (cfg_tmo_en),
        .dma_en    (dma_en),
        .tmo_en    (tmo_en)
    );

    arb_sess_timer #(.LIMIT(LIMIT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .granted (granted),
        .req_act (req_act),
        .tmo_en  (tmo_en),
        .expire  (expire)
    );

    always_comb begin
        st_d     = st_q;
        st_d.exc = 1'b0;
        unique case (st_q.owner)
            ST_CPU: begin
                if (req_act && dma_en && !cpu_lock && bus_idle) begin
                    st_d.owner = ST_DMA;
                end
            end
            ST_DMA: begin
                if (bus_tmo || expire) begin
                    st_d.owner = ST_HOLD;
                    st_d.exc   = 1'b1;
                end else if (!req_act && !data_rdy_n) begin
                    st_d.owner = ST_CPU;
                end else if (!dma_en && bus_idle) begin
                    st_d.owner = ST_CPU;
                end
            end
            ST_HOLD: begin
                if (!req_act) begin
                    st_d.owner = ST_CPU;
                end
            end
            default: st_d.owner = ST_CPU;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.owner <= ST_CPU;
            st_q.exc   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dma_gnt_n = !granted;
    assign mem_exc   = st_q.exc;

    // R3
    grant_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_gnt_n) |-> $past(!cpu_lock));

    // R4
    grant_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_gnt_n) |-> $past(bus_idle));

    // R5
    grant_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_gnt_n) |-> $past(dma_en));

    // R11
    exc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_exc |=> !mem_exc);

    // R9
    exc_revoke_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_exc |-> (dma_gnt_n && $past(!dma_gnt_n)));

    // R10
    no_regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_exc && !dma_req_n) |=> dma_gnt_n);

endmodule

// File: tb/dma_bus_arbiter_test.sv
module dma_bus_arbiter_test;
    localparam int LIMIT = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_dma_en = 1'b0, cfg_tmo_en = 1'b0;
    logic dma_req_n = 1'b1, cpu_lock = 1'b0, bus_idle = 1'b1;
    logic data_rdy_n = 1'b1, bus_tmo = 1'b0;
    logic dma_gnt_n, mem_exc;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_bus_arbiter #(.LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dma_en(cfg_dma_en),
        .cfg_tmo_en(cfg_tmo_en), .dma_req_n(dma_req_n), .cpu_lock(cpu_lock),
        .bus_idle(bus_idle), .data_rdy_n(data_rdy_n), .bus_tmo(bus_tmo),
        .dma_gnt_n(dma_gnt_n), .mem_exc(mem_exc)
    );

    // {req tag[3:0], req_n, lock, idle, drdy_n, bus_tmo, exp_gnt_n, exp_exc}
    localparam int NV = 14;
    localparam logic [10:0] VEC [NV] = '{
        {4'd2,  5'b10110, 2'b10},  // R2 no request, no grant
        {4'd3,  5'b01110, 2'b10},  // R3 locked cycle blocks grant
        {4'd4,  5'b00010, 2'b10},  // R4 busy bus blocks grant
        {4'd2,  5'b00110, 2'b00},  // R2 grant
        {4'd6,  5'b00010, 2'b00},  // R6 session continues
        {4'd6,  5'b10010, 2'b00},  // R6 request high, no handshake: hold
        {4'd6,  5'b10100, 2'b10},  // R6 handshake: release
        {4'd2,  5'b00110, 2'b00},  // R2 grant again
        {4'd9,  5'b00111, 2'b11},  // R9 bus timeout revokes
        {4'd10, 5'b00110, 2'b10},  // R10 request still low: no grant
        {4'd10, 5'b10110, 2'b10},  // R10 request seen high
        {4'd10, 5'b00110, 2'b00},  // R10 grant reissued
        {4'd6,  5'b10100, 2'b10},  // R6 release
        {4'd9,  5'b10111, 2'b10}   // R9 timeout ignored while CPU owns
    };

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg(input logic en, input logic tmo);
        cfg_we = 1'b1; cfg_dma_en = en; cfg_tmo_en = tmo;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        step();
        rst_n = 1'b1;
        // R1 reset state
        chk(dma_gnt_n, 1'b1, "R1", "grant after reset");
        chk(mem_exc, 1'b0, "R1", "exception after reset");
        dma_req_n = 1'b0;
        step();
        chk(dma_gnt_n, 1'b1, "R1", "DMA disabled after reset");
        dma_req_n = 1'b1;
        step();

        // R12 enable through control write
        cfg(1'b1, 1'b1);
        for (int i = 0; i < NV; i++) begin
            dma_req_n  = VEC[i][6];
            cpu_lock   = VEC[i][5];
            bus_idle   = VEC[i][4];
            data_rdy_n = VEC[i][3];
            bus_tmo    = VEC[i][2];
            step();
            chk(dma_gnt_n, VEC[i][1], $sformatf("R%0d", VEC[i][10:7]), $sformatf("vec %0d grant", i));
            chk(mem_exc, VEC[i][0], $sformatf("R%0d", VEC[i][10:7]), $sformatf("vec %0d exception", i));
        end
        dma_req_n = 1'b1; cpu_lock = 1'b0; bus_idle = 1'b1; data_rdy_n = 1'b1; bus_tmo = 1'b0;
        step();

        // R5 disabled DMA blocks grant
        cfg(1'b0, 1'b1);
        dma_req_n = 1'b0;
        step();
        chk(dma_gnt_n, 1'b1, "R5", "grant while disabled");
        // R12 enable takes effect from next edge
        cfg_we = 1'b1; cfg_dma_en = 1'b1; cfg_tmo_en = 1'b1;
        step();
        cfg_we = 1'b0;
        chk(dma_gnt_n, 1'b1, "R12", "grant in load cycle");
        step();
        chk(dma_gnt_n, 1'b0, "R12", "grant after load");
        // R5 disable during session, withdraw only at idle point
        bus_idle = 1'b0;
        cfg(1'b0, 1'b1);
        step();
        chk(dma_gnt_n, 1'b0, "R5", "grant held while bus busy");
        bus_idle = 1'b1;
        step();
        chk(dma_gnt_n, 1'b1, "R5", "grant withdrawn at idle");
        chk(mem_exc, 1'b0, "R5", "no exception on withdraw");
        dma_req_n = 1'b1;
        step();

        // R7 watchdog limit counted exactly
        cfg(1'b1, 1'b1);
        dma_req_n = 1'b0;
        begin
            int low_cnt = 0;
            bit exc_seen = 1'b0;
            for (int c = 0; c < LIMIT + 10; c++) begin
                step();
                if (dma_gnt_n == 1'b0) low_cnt++;
                else begin
                    exc_seen = mem_exc;
                    break;
                end
            end
            chk(low_cnt == LIMIT, 1'b1, "R7", "grant cycles equal limit");
            chk(exc_seen, 1'b1, "R7", "exception at revocation");
        end
        step();
        chk(mem_exc, 1'b0, "R11", "exception lasts one cycle");
        chk(dma_gnt_n, 1'b1, "R10", "no grant while request held");
        dma_req_n = 1'b1;
        step();

        // R8 watchdog disabled
        cfg(1'b1, 1'b0);
        dma_req_n = 1'b0;
        begin
            bit exc_any = 1'b0;
            bit gnt_lost = 1'b0;
            step();
            for (int c = 0; c < LIMIT + 100; c++) begin
                step();
                if (mem_exc) exc_any = 1'b1;
                if (dma_gnt_n) gnt_lost = 1'b1;
            end
            chk(exc_any, 1'b0, "R8", "no exception with watchdog off");
            chk(gnt_lost, 1'b0, "R8", "grant kept with watchdog off");
        end
        dma_req_n = 1'b1; data_rdy_n = 1'b0;
        step();
        chk(dma_gnt_n, 1'b1, "R6", "release after long session");
        data_rdy_n = 1'b1;
        step();

        done = 1'b1;
        finish_run();
    end

endmodule